// File: doc/BRIEF.md
# Program Counter Sampling Unit

This block records the addresses of committed instructions so that an external debug agent can collect statistical profiles of running code. The processor's retire interface reports each committed instruction. On that cycle a holding register captures one address. It is the retiring address for an ordinary instruction. For a branch it is the taken target, or the next sequential address when the branch's condition fails. For an exception it is the vector address. Instructions that are fetched but never retire do not reach the holding register.

A small register read port gives the agent access to the samples. The PC sample register answers at two indices, 40 and 33, with identical contents. A read of either index also copies the current context identifier into a context sample register, which answers at index 41. When debug sampling is not permitted, a PC sample read returns all ones and the context sample is left undefined. Indices that are not implemented read as zero, and writes to any index are ignored.

Top module: `pc_sampler`

## Requirements
- R1: After reset, the holding register and the context sample register are zero. rd_data_o is also zero, and reads of indices 40 and 41 return zero.
- R2: On a cycle with ret_valid_i high and ret_branch_i and ret_exc_i low, the holding register loads ret_pc_i at that clock edge.
- R3: On a retire with ret_branch_i and br_taken_i high and ret_exc_i low, the holding register loads br_target_i.
- R4: On a retire with ret_branch_i high, br_taken_i low and ret_exc_i low, the holding register loads ret_pc_i + INSN_BYTES (default 4).
- R5: On a retire with ret_exc_i high, the holding register loads exc_vector_i. This takes priority over any branch information on the same cycle.
- R6: While ret_valid_i is low, the holding register keeps its value, whatever the other retire inputs do.
- R7: A read with rd_en_i high at index 40 or index 33 sets rd_data_o at that clock edge to the holding register's value from before the edge. A retire on the same cycle is therefore not seen by that read.
- R8: A permitted PC sample read loads ctx_id_i into the context sample register at the same edge.
- R9: A PC sample read returns 0xFFFFFFFF when any of these holds: nid_en_i is low, mode_nid_ok_i is low, or debug_state_i is high.
- R10: A read of index 41 returns the last value loaded into the context sample register and does not change it.
- R11: A read of any index other than 33, 40 or 41 returns zero.
- R12: A write (wr_en_i high) to any index changes neither the holding register nor the context sample register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_valid_i | input | 1 | An instruction commits this cycle |
| ret_pc_i | input | ADDR_W | Address of the committing instruction |
| ret_branch_i | input | 1 | The committing instruction is a branch |
| br_taken_i | input | 1 | The branch passed its condition and is taken |
| br_target_i | input | ADDR_W | Target of the taken branch |
| ret_exc_i | input | 1 | An exception is taken on this commit |
| exc_vector_i | input | ADDR_W | Exception vector address |
| ctx_id_i | input | CTX_W | Current context identifier |
| nid_en_i | input | 1 | Non-invasive debug is enabled |
| mode_nid_ok_i | input | 1 | The current mode permits non-invasive debug |
| debug_state_i | input | 1 | The processor is halted in debug state |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe (has no effect) |
| reg_idx_i | input | IDX_W | Register index for the access |
| wr_data_i | input | ADDR_W | Write data (discarded) |
| rd_data_o | output | ADDR_W | Registered read data |

## Verification
Every result in this block is due one clock edge after the stimulus. A retire updates the holding register at the edge where ret_valid_i is sampled. A read updates rd_data_o and the context sample register at the edge where rd_en_i is sampled. The bench drives its inputs just after a rising edge, waits for the next rising edge, and samples one time unit later. A retire placed on the same cycle as a read is checked to return the older value, and the value it retired is then checked with a second read. Results that the requirements call undefined, such as the context sample after a refused read, are never compared.

// File: rtl/pc_sampler_pkg.sv
package pc_sampler_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,
    SRC_FALL = 2'd1,
    SRC_TGT  = 2'd2,
    SRC_VEC  = 2'd3
  } smp_src_e;
endpackage

// File: rtl/pc_src_sel.sv
module pc_src_sel
  import pc_sampler_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              ret_branch_i,
  input  logic              br_taken_i,
  input  logic              ret_exc_i,
  input  logic [ADDR_W-1:0] ret_pc_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic [ADDR_W-1:0] exc_vector_i,
  output smp_src_e          src_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  // exception outranks branch outranks sequential
  always_comb begin
    if (ret_exc_i)                       src_o = SRC_VEC;
    else if (ret_branch_i && br_taken_i) src_o = SRC_TGT;
    else if (ret_branch_i)               src_o = SRC_FALL;
    else                                 src_o = SRC_SEQ;
  end

  always_comb begin
    unique case (src_o)
      SRC_VEC:  addr_o = exc_vector_i;
      SRC_TGT:  addr_o = br_target_i;
      SRC_FALL: addr_o = ret_pc_i + STEP;
      default:  addr_o = ret_pc_i;
    endcase
  end
endmodule

// File: rtl/pc_hold_reg.sv
module pc_hold_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_o <= '0;
    else if (upd_i) hold_o <= addr_i;
  end

  p_hold_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(hold_o));
  p_hold_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> hold_o == $past(addr_i));
endmodule

// File: rtl/smp_rd_port.sv
module smp_rd_port #(
  parameter int ADDR_W   = 32,
  parameter int CTX_W    = 32,
  parameter int IDX_W    = 6,
  parameter int PC_IDX   = 40,
  parameter int PC_ALIAS = 33,
  parameter int CTX_IDX  = 41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              permit_i,
  input  logic [ADDR_W-1:0] hold_i,
  input  logic [CTX_W-1:0]  ctx_id_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  localparam logic [IDX_W-1:0] IDX_PC  = IDX_W'(PC_IDX);
  localparam logic [IDX_W-1:0] IDX_PCA = IDX_W'(PC_ALIAS);
  localparam logic [IDX_W-1:0] IDX_CTX = IDX_W'(CTX_IDX);

  logic             hit_pc, hit_ctx;
  logic [CTX_W-1:0] ctx_q;
  logic [ADDR_W-1:0] rd_next;

  assign hit_pc  = (reg_idx_i == IDX_PC) || (reg_idx_i == IDX_PCA);
  assign hit_ctx = (reg_idx_i == IDX_CTX);

  always_comb begin
    if (hit_pc)       rd_next = permit_i ? hold_i : '1;
    else if (hit_ctx) rd_next = ADDR_W'(ctx_q);
    else              rd_next = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rd_data_o <= '0;
    else if (rd_en_i)   rd_data_o <= rd_next;
  end

  // refused read leaves ctx_q as is (value is undefined by contract)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ctx_q <= '0;
    else if (rd_en_i && hit_pc && permit_i) ctx_q <= ctx_id_i;
  end

  p_ctx_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && hit_pc && permit_i |=> ctx_q == $past(ctx_id_i));
  p_all_ones_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && hit_pc && !permit_i |=> rd_data_o == '1);
  p_pc_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && hit_pc && permit_i |=> rd_data_o == $past(hold_i));
  p_ctx_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && hit_ctx |=> $stable(ctx_q));
  p_unimpl_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !hit_pc && !hit_ctx |=> rd_data_o == '0);
  p_wr_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !rd_en_i && (wr_data_i != rd_data_o) |=> $stable(ctx_q) && $stable(rd_data_o));
endmodule

// File: rtl/pc_sampler.sv
module pc_sampler
  import pc_sampler_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CTX_W      = 32,
  parameter int IDX_W      = 6,
  parameter int INSN_BYTES = 4,
  parameter int PC_IDX     = 40,
  parameter int PC_ALIAS   = 33,
  parameter int CTX_IDX    = 41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ret_valid_i,
  input  logic [ADDR_W-1:0] ret_pc_i,
  input  logic              ret_branch_i,
  input  logic              br_taken_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic              ret_exc_i,
  input  logic [ADDR_W-1:0] exc_vector_i,
  input  logic [CTX_W-1:0]  ctx_id_i,
  input  logic              nid_en_i,
  input  logic              mode_nid_ok_i,
  input  logic              debug_state_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  smp_src_e          src;
  logic [ADDR_W-1:0] sel_addr, hold;
  logic              permit;

  assign permit = nid_en_i && mode_nid_ok_i && !debug_state_i;

  pc_src_sel #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_sel (
    .ret_branch_i (ret_branch_i),
    .br_taken_i   (br_taken_i),
    .ret_exc_i    (ret_exc_i),
    .ret_pc_i     (ret_pc_i),
    .br_target_i  (br_target_i),
    .exc_vector_i (exc_vector_i),
    .src_o        (src),
    .addr_o       (sel_addr)
  );

  pc_hold_reg #(.ADDR_W(ADDR_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (ret_valid_i),
    .addr_i (sel_addr),
    .hold_o (hold)
  );

  smp_rd_port #(
    .ADDR_W(ADDR_W), .CTX_W(CTX_W), .IDX_W(IDX_W),
    .PC_IDX(PC_IDX), .PC_ALIAS(PC_ALIAS), .CTX_IDX(CTX_IDX)
  ) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .reg_idx_i (reg_idx_i),
    .wr_data_i (wr_data_i),
    .permit_i  (permit),
    .hold_i    (hold),
    .ctx_id_i  (ctx_id_i),
    .rd_data_o (rd_data_o)
  );

  p_exc_vec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && ret_exc_i |=> hold == $past(exc_vector_i));
  p_taken_tgt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && !ret_exc_i && ret_branch_i && br_taken_i |=> hold == $past(br_target_i));
  p_src_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_branch_i && !br_taken_i && !ret_exc_i |-> src == SRC_FALL);
endmodule

// File: tb/pc_sampler_bench.sv
module pc_sampler_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 0, rst_n = 0;
  logic        ret_valid = 0, ret_branch = 0, br_taken = 0, ret_exc = 0;
  logic [31:0] ret_pc = 0, br_target = 0, exc_vector = 0, ctx_id = 0;
  logic        nid_en = 1, mode_ok = 1, dbg_state = 0;
  logic        rd_en = 0, wr_en = 0;
  logic [5:0]  reg_idx = 0;
  logic [31:0] wr_data = 0, rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sampler u_pc_sampler (
    .clk_i(clk), .rst_ni(rst_n), .ret_valid_i(ret_valid), .ret_pc_i(ret_pc),
    .ret_branch_i(ret_branch), .br_taken_i(br_taken), .br_target_i(br_target),
    .ret_exc_i(ret_exc), .exc_vector_i(exc_vector), .ctx_id_i(ctx_id),
    .nid_en_i(nid_en), .mode_nid_ok_i(mode_ok), .debug_state_i(dbg_state),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .reg_idx_i(reg_idx), .wr_data_i(wr_data),
    .rd_data_o(rd_data)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] idx, output logic [31:0] v);
    rd_en = 1; reg_idx = idx; tick(); v = rd_data; rd_en = 0;
  endtask

  task automatic retire(logic [31:0] pc, logic br, logic tk, logic [31:0] tgt,
                        logic ex, logic [31:0] vec);
    ret_valid = 1; ret_pc = pc; ret_branch = br; br_taken = tk;
    br_target = tgt; ret_exc = ex; exc_vector = vec;
    tick();
    ret_valid = 0; ret_branch = 0; br_taken = 0; ret_exc = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rd_data", rd_data, 32'h0);
    rd(6'd40, v); check("R1 pc", v, 32'h0);
    rd(6'd41, v); check("R1 ctx", v, 32'h0);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    retire(32'h0000_1230, 0, 0, 32'h0, 0, 32'h0);
    rd(6'd40, v); check("R2 idx40", v, 32'h0000_1230);
    rd(6'd33, v); check("R7 idx33", v, 32'h0000_1230);
  endtask

  task automatic t_branches();
    logic [31:0] v;
    retire(32'h0000_2000, 1, 1, 32'h0000_8000, 0, 32'h0);
    rd(6'd40, v); check("R3 taken", v, 32'h0000_8000);
    retire(32'h0000_1000, 1, 0, 32'h0000_9000, 0, 32'h0);
    rd(6'd40, v); check("R4 fallthrough", v, 32'h0000_1004);
    retire(32'h0000_3000, 1, 1, 32'h0000_7000, 1, 32'hFFFF_0018);
    rd(6'd33, v); check("R5 vector", v, 32'hFFFF_0018);
  endtask

  task automatic t_no_commit();
    logic [31:0] v;
    ret_valid = 0; ret_pc = 32'hDEAD_0000; ret_branch = 1; br_taken = 1;
    br_target = 32'hBEEF_0000; ret_exc = 1; exc_vector = 32'h0000_0040;
    tick(); tick();
    ret_branch = 0; br_taken = 0; ret_exc = 0;
    rd(6'd40, v); check("R6 uncommitted", v, 32'hFFFF_0018);
  endtask

  task automatic t_coincide();
    logic [31:0] v;
    ret_valid = 1; ret_pc = 32'h0000_5550; rd_en = 1; reg_idx = 6'd40;
    tick();
    ret_valid = 0; rd_en = 0;
    check("R7 same-cycle old", rd_data, 32'hFFFF_0018);
    rd(6'd40, v); check("R7 next read new", v, 32'h0000_5550);
  endtask

  task automatic t_ctx();
    logic [31:0] v;
    ctx_id = 32'h0000_ABCD;
    rd(6'd40, v);
    ctx_id = 32'h1111_2222;
    rd(6'd41, v); check("R8 ctx latched", v, 32'h0000_ABCD);
    rd(6'd41, v); check("R10 ctx repeat", v, 32'h0000_ABCD);
    rd(6'd33, v);
    ctx_id = 32'h0;
    rd(6'd41, v); check("R8 alias latch", v, 32'h1111_2222);
  endtask

  task automatic t_refused();
    logic [31:0] v;
    nid_en = 0;    rd(6'd40, v); check("R9 nid off", v, ONES); nid_en = 1;
    mode_ok = 0;   rd(6'd33, v); check("R9 mode", v, ONES);    mode_ok = 1;
    dbg_state = 1; rd(6'd40, v); check("R9 debug", v, ONES);   dbg_state = 0;
    rd(6'd40, v); check("R9 restored", v, 32'h0000_5550);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    rd(6'd0, v);  check("R11 idx0", v, 32'h0);
    rd(6'd34, v); check("R11 idx34", v, 32'h0);
    rd(6'd63, v); check("R11 idx63", v, 32'h0);
  endtask

  task automatic t_writes();
    logic [31:0] v;
    ctx_id = 32'h0000_7777;
    rd(6'd40, v);
    wr_en = 1; wr_data = 32'h1234_5678;
    reg_idx = 6'd40; tick();
    reg_idx = 6'd41; tick();
    reg_idx = 6'd33; tick();
    wr_en = 0;
    rd(6'd41, v); check("R12 ctx kept", v, 32'h0000_7777);
    rd(6'd40, v); check("R12 pc kept", v, 32'h0000_5550);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_plain();
    t_branches();
    t_no_commit();
    t_coincide();
    t_ctx();
    t_refused();
    t_unimpl();
    t_writes();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule